// File: doc/BRIEF.md
# Three-Level PWM Gate Sequencer

This block converts one decoded three-level PWM command into the two gate enables of a synchronous buck power stage. A high command selects the high-side switch and a low command selects the low-side switch. Each turn-on waits for the opposite switch to be sensed off and then for a dead-time. A middle command takes the stage to a high-impedance state in which both gates are off. The path into that state depends on which switch was conducting before. The sequencer enters it through a hold-off interval, which keeps the low-side gate on while the hold-off runs.

A light-load mode can be selected. In this mode a low command opens the low-side gate for a blanking interval. After the blanking, the gate closes on the first zero-cross indication. It then stays closed until the next high command. An enable controller supplies a run permit, which clears the sequencer at once. When the permit returns, the sequencer starts in a prebias-safe way. All durations are parameters counted in clock cycles.

Top module: `gseq_top`

## Requirements
- R1: The command code is decoded as 2'b00 low, 2'b01 middle and 2'b10 high. When a high code arrives, the low-side gate drops at the first clock edge. The high-side gate rises DEAD_CYC edges after the first edge at which the low-side off-sense is seen, so it rises DEAD_CYC+1 edges after the code if the sense is already asserted.
- R2: A low code in normal mode drops the high-side gate at the first edge. The low-side gate rises DEAD_CYC+1 edges after the code when the high-side off-sense is asserted.
- R3: The high-side gate stays off for as long as the low-side off-sense is deasserted. It rises DEAD_CYC edges after the sense asserts.
- R4: On a change from low to middle, the low-side gate stays on for HOLD_CYC more cycles and falls at edge HOLD_CYC+1. The high-side gate stays off.
- R5: On a change from high to middle, the high-side gate falls at the first edge. The low-side gate rises DEAD_CYC+1 edges after the code and stays on for exactly HOLD_CYC cycles. After that both gates stay off.
- R6: In zero-current mode the zero-cross bit is ignored during the first BLANK_CYC cycles of the low-side pulse. If the bit is held high, the pulse lasts exactly BLANK_CYC+1 cycles.
- R7: In zero-current mode with no zero-cross indication, the low-side gate stays on while the command stays low.
- R8: After a zero-cross trip, the low-side gate stays off through later low and middle codes. Only a high code restarts the sequence.
- R9: In normal mode the zero-cross bit has no effect on the low-side gate.
- R10: Code 2'b11, which is what a floating input reads as, behaves exactly like middle. A change between 2'b01 and 2'b11 is not a new command.
- R11: Every new code restarts the timers. A low code that arrives during a hold-off keeps the low-side gate on without a gap, and the hold-off counts again from the next middle code.
- R12: The two gate enables are never high in the same cycle.
- R13: When the run permit is low, both gates are low after the next clock edge and all timers are cleared.
- R14: When the permit rises while the code is low in normal mode, the low-side gate rises DEAD_CYC+1 edges later. In every other case both gates stay off until the code changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_ok | input | 1 | Run permit from the enable controller |
| pwm_code | input | 2 | Decoded PWM command (00 low, 01 middle, 10 high, 11 floating) |
| zcd_mode | input | 1 | Selects zero-current mode |
| zc_trip | input | 1 | Zero-cross comparator: switch node at or above threshold |
| ls_off | input | 1 | Low-side switch sensed off |
| hs_off | input | 1 | High-side switch sensed off |
| gh_en | output | 1 | High-side gate enable |
| gl_en | output | 1 | Low-side gate enable |

## Verification
Two functions can fall in the same cycle: a new command code and the expiry of a running timer or blanking window. The bench provokes this by sending a low code partway through a hold-off and a high code partway through a dead-time. It then judges that the low-side gate has no gap and that the latency restarts in full from the last code. The same sweep checks that a zero-cross indication which overlaps the blanking window ends the pulse exactly one cycle after the window closes, and never earlier.

// File: rtl/gseq_pkg.sv
package gseq_pkg;

    typedef enum logic [1:0] {
        CMD_LOW   = 2'b00,
        CMD_MID   = 2'b01,
        CMD_HIGH  = 2'b10,
        CMD_FLOAT = 2'b11
    } cmd_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HS_WAIT,
        ST_HS_ON,
        ST_LS_WAIT,
        ST_LS_ON,
        ST_HOLD_LS,
        ST_PULSE_WAIT,
        ST_PULSE_LS,
        ST_ZC_DONE
    } seq_state_t;

    typedef struct packed {
        cmd_t code;
        logic event_new;
        logic started;
    } cmd_info_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

    function automatic cmd_t fold_cmd(input logic [1:0] raw);
        return (raw == 2'b11) ? CMD_MID : cmd_t'(raw);
    endfunction

    function automatic logic ls_driven(input seq_state_t s);
        return (s == ST_LS_ON) || (s == ST_HOLD_LS) || (s == ST_PULSE_LS);
    endfunction

endpackage

// File: rtl/gseq_cmd_track.sv
module gseq_cmd_track
    import gseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run_ok,
    input  logic [1:0] raw_code,
    output cmd_info_t  info
);
    cmd_t code_f;
    cmd_t prev_q;
    logic run_q;

    assign code_f = fold_cmd(raw_code);

    always_ff @(posedge clk) begin
        prev_q <= code_f;
        if (rst || !run_ok) begin
            run_q <= 1'b0;
        end else begin
            run_q <= 1'b1;
        end
    end

    always_comb begin
        info.code      = code_f;
        info.event_new = run_q && (code_f != prev_q);
        info.started   = run_q;
    end
endmodule

// File: rtl/gseq_timer.sv
module gseq_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/gseq_fsm.sv
module gseq_fsm
    import gseq_pkg::*;
#(
    parameter int DEAD_CYC  = 3,
    parameter int HOLD_CYC  = 5,
    parameter int BLANK_CYC = 4,
    parameter int CW        = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run_ok,
    input  cmd_info_t     info,
    input  logic          zcd_mode,
    input  logic          zc_trip,
    input  logic          ls_off,
    input  logic          hs_off,
    input  logic [CW-1:0] cnt,
    output logic          t_clr,
    output logic          t_inc,
    output seq_state_t    state
);
    localparam logic [CW-1:0] DEAD_LAST  = CW'(DEAD_CYC - 1);
    localparam logic [CW-1:0] HOLD_LAST  = CW'(HOLD_CYC - 1);
    localparam logic [CW-1:0] BLANK_END  = CW'(BLANK_CYC);

    seq_state_t nxt;
    logic       step_clr;

    always_comb begin
        nxt      = state;
        step_clr = 1'b0;
        t_inc    = 1'b0;
        if (info.event_new) begin
            step_clr = 1'b1;
            unique case (info.code)
                CMD_HIGH: nxt = ST_HS_WAIT;
                CMD_LOW: begin
                    if (state == ST_ZC_DONE)      nxt = ST_ZC_DONE;
                    else if (ls_driven(state))    nxt = ST_LS_ON;
                    else                          nxt = ST_LS_WAIT;
                end
                default: begin
                    unique case (state)
                        ST_HS_ON:   nxt = ST_PULSE_WAIT;
                        ST_LS_ON:   nxt = ST_HOLD_LS;
                        ST_ZC_DONE: nxt = ST_ZC_DONE;
                        default:    nxt = ST_IDLE;
                    endcase
                end
            endcase
        end else if (!info.started) begin
            step_clr = 1'b1;
            nxt = (!zcd_mode && info.code == CMD_LOW) ? ST_LS_WAIT : ST_IDLE;
        end else begin
            unique case (state)
                ST_HS_WAIT: begin
                    if (!ls_off)                step_clr = 1'b1;
                    else if (cnt == DEAD_LAST)  nxt = ST_HS_ON;
                    else                        t_inc = 1'b1;
                end
                ST_LS_WAIT: begin
                    if (!hs_off)                step_clr = 1'b1;
                    else if (cnt == DEAD_LAST)  nxt = ST_LS_ON;
                    else                        t_inc = 1'b1;
                end
                ST_PULSE_WAIT: begin
                    if (!hs_off)                step_clr = 1'b1;
                    else if (cnt == DEAD_LAST)  nxt = ST_PULSE_LS;
                    else                        t_inc = 1'b1;
                end
                ST_PULSE_LS, ST_HOLD_LS: begin
                    if (cnt == HOLD_LAST)       nxt = ST_IDLE;
                    else                        t_inc = 1'b1;
                end
                ST_LS_ON: begin
                    if (zcd_mode) begin
                        if (cnt == BLANK_END) begin
                            if (zc_trip) nxt = ST_ZC_DONE;
                        end else begin
                            t_inc = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign t_clr = rst || !run_ok || step_clr || (nxt != state);

    always_ff @(posedge clk) begin
        if (rst || !run_ok) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // R8: a tripped pulse stays closed until a high command
    a_r8_trip_latched: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ZC_DONE && run_ok && info.code != CMD_HIGH) |=> (state == ST_ZC_DONE));

    // R13: timers are cleared while the permit is low
    a_r13_timer_clear: assert property (@(posedge clk) disable iff (rst)
        !run_ok |=> (cnt == '0));
endmodule

// File: rtl/gseq_top.sv
module gseq_top
    import gseq_pkg::*;
#(
    parameter int DEAD_CYC  = 3,
    parameter int HOLD_CYC  = 5,
    parameter int BLANK_CYC = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run_ok,
    input  logic [1:0] pwm_code,
    input  logic       zcd_mode,
    input  logic       zc_trip,
    input  logic       ls_off,
    input  logic       hs_off,
    output logic       gh_en,
    output logic       gl_en
);
    localparam int MAXV = max3(DEAD_CYC, HOLD_CYC, BLANK_CYC);
    localparam int CW   = $clog2(MAXV + 1) + 1;

    cmd_info_t     info;
    seq_state_t    state;
    logic [CW-1:0] cnt;
    logic          t_clr;
    logic          t_inc;

    gseq_cmd_track u_track (
        .clk      (clk),
        .rst      (rst),
        .run_ok   (run_ok),
        .raw_code (pwm_code),
        .info     (info)
    );

    gseq_timer #(.CW(CW)) u_timer (
        .clk (clk),
        .clr (t_clr),
        .inc (t_inc),
        .cnt (cnt)
    );

    gseq_fsm #(
        .DEAD_CYC  (DEAD_CYC),
        .HOLD_CYC  (HOLD_CYC),
        .BLANK_CYC (BLANK_CYC),
        .CW        (CW)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .run_ok   (run_ok),
        .info     (info),
        .zcd_mode (zcd_mode),
        .zc_trip  (zc_trip),
        .ls_off   (ls_off),
        .hs_off   (hs_off),
        .cnt      (cnt),
        .t_clr    (t_clr),
        .t_inc    (t_inc),
        .state    (state)
    );

    assign gh_en = (state == ST_HS_ON);
    assign gl_en = ls_driven(state);

    // R12: never both gates on
    a_r12_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(gh_en && gl_en));

    // R1: high side only turns on after low side was sensed off
    a_r1_gh_needs_ls_off: assert property (@(posedge clk) disable iff (rst)
        $rose(gh_en) |-> $past(ls_off));

    // R2: low side only turns on after high side was sensed off
    a_r2_gl_needs_hs_off: assert property (@(posedge clk) disable iff (rst)
        $rose(gl_en) |-> $past(hs_off));

    // R13: permit low clears both gates at the next edge
    a_r13_permit_off: assert property (@(posedge clk) disable iff (rst)
        !run_ok |=> (!gh_en && !gl_en));
endmodule

// File: tb/tb_gseq_top.sv
module tb_gseq_top;
    localparam int DEAD  = 3;
    localparam int HOLD  = 5;
    localparam int BLANK = 4;

    logic       clk = 1'b0;
    logic       rst, run_ok, zcd_mode, zc_trip;
    logic [1:0] pwm_code;
    logic       frc_ls, frc_hs;
    logic       ls_off, hs_off, gh_en, gl_en;
    int         checks = 0;
    int         errors = 0;
    int         overlap = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    assign ls_off = frc_ls ? 1'b0 : ~gl_en;
    assign hs_off = frc_hs ? 1'b0 : ~gh_en;

    gseq_top #(.DEAD_CYC(DEAD), .HOLD_CYC(HOLD), .BLANK_CYC(BLANK)) dut (
        .clk(clk), .rst(rst), .run_ok(run_ok), .pwm_code(pwm_code),
        .zcd_mode(zcd_mode), .zc_trip(zc_trip), .ls_off(ls_off),
        .hs_off(hs_off), .gh_en(gh_en), .gl_en(gl_en)
    );

    always @(negedge clk) if (!rst && gh_en && gl_en) overlap++;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // edges until gate reaches level (gh when sel=1, gl when sel=0)
    task automatic edges_until(input bit sel, input bit lvl, output int n);
        n = 0;
        do begin
            cyc(1);
            n++;
        end while ((sel ? gh_en : gl_en) != lvl && n < 60);
    endtask

    task automatic stay(input string tag, input int n, input bit egh, input bit egl);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            cyc(1);
            if (gh_en != egh || gl_en != egl) bad++;
        end
        chk(tag, bad, 0);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n;
        rst = 1; run_ok = 1; pwm_code = 2'b01; zcd_mode = 0; zc_trip = 0;
        frc_ls = 0; frc_hs = 0;
        cyc(3);
        chk("reset gh", gh_en, 0);
        chk("reset gl", gl_en, 0);
        rst = 0;
        cyc(3);

        // R1: high from idle
        pwm_code = 2'b10;
        edges_until(1, 1, n);
        chk("R1 gh latency", n, DEAD + 1);
        chk("R1 gl off", gl_en, 0);

        // R2: low from high
        pwm_code = 2'b00;
        cyc(1);
        chk("R2 gh drops at first edge", gh_en, 0);
        edges_until(0, 1, n);
        chk("R2 gl latency", n + 1, DEAD + 1);

        // R4: low to middle
        pwm_code = 2'b01;
        edges_until(0, 0, n);
        chk("R4 gl hold-off fall edge", n, HOLD + 1);
        stay("R4 both off after hold-off", 6, 0, 0);

        // R5: high to middle
        pwm_code = 2'b10;
        cyc(DEAD + 3);
        pwm_code = 2'b01;
        cyc(1);
        chk("R5 gh drops at first edge", gh_en, 0);
        edges_until(0, 1, n);
        chk("R5 gl pulse start", n + 1, DEAD + 1);
        edges_until(0, 0, n);
        chk("R5 gl pulse width", n, HOLD);
        stay("R5 both off after pulse", 8, 0, 0);

        // R3: wait for low-side off sense
        pwm_code = 2'b00;
        cyc(DEAD + 3);
        frc_ls = 1;
        pwm_code = 2'b10;
        stay("R3 gh held while low side on", 10, 0, 0);
        frc_ls = 0;
        edges_until(1, 1, n);
        chk("R3 gh after sense", n, DEAD);

        // R10: floating code behaves as middle
        pwm_code = 2'b00;
        cyc(DEAD + 3);
        pwm_code = 2'b11;
        edges_until(0, 0, n);
        chk("R10 floating hold-off fall", n, HOLD + 1);
        pwm_code = 2'b01;
        stay("R10 01/11 swap no event", 6, 0, 0);

        // R11: low during hold-off keeps gl, hold-off restarts
        pwm_code = 2'b00;
        cyc(DEAD + 3);
        pwm_code = 2'b01;
        stay("R11 gl kept in hold-off", 2, 0, 1);
        pwm_code = 2'b00;
        stay("R11 gl no gap on restart", 3, 0, 1);
        pwm_code = 2'b01;
        edges_until(0, 0, n);
        chk("R11 hold-off recounted", n, HOLD + 1);

        // R11: dead-time restart on high
        pwm_code = 2'b10;
        cyc(2);
        pwm_code = 2'b01;
        cyc(1);
        pwm_code = 2'b10;
        edges_until(1, 1, n);
        chk("R11 dead-time recounted", n, DEAD + 1);

        // R9: trip ignored in normal mode
        zc_trip = 1;
        pwm_code = 2'b00;
        cyc(DEAD + 2);
        stay("R9 gl unaffected by trip", 20, 0, 1);
        zc_trip = 0;

        // R6: blanking then trip
        zcd_mode = 1;
        pwm_code = 2'b10;
        cyc(DEAD + 3);
        zc_trip = 1;
        pwm_code = 2'b00;
        edges_until(0, 1, n);
        chk("R6 gl start in zero-current mode", n, DEAD + 1);
        edges_until(0, 0, n);
        chk("R6 gl width with trip held", n, BLANK + 1);

        // R8: stays off until high
        pwm_code = 2'b01;
        stay("R8 off under middle", 5, 0, 0);
        pwm_code = 2'b00;
        stay("R8 off under low", 10, 0, 0);
        zc_trip = 0;
        pwm_code = 2'b10;
        edges_until(1, 1, n);
        chk("R8 high restarts", n, DEAD + 1);

        // R7: no trip keeps gl on
        pwm_code = 2'b00;
        cyc(DEAD + 2);
        stay("R7 gl held without trip", 20, 0, 1);

        // R13: permit removal
        zcd_mode = 0;
        pwm_code = 2'b10;
        cyc(DEAD + 3);
        run_ok = 0;
        cyc(1);
        chk("R13 gh off after one edge", gh_en, 0);
        chk("R13 gl off after one edge", gl_en, 0);
        pwm_code = 2'b00;
        stay("R13 off while disabled", 5, 0, 0);

        // R14: restart low in normal mode
        run_ok = 1;
        edges_until(0, 1, n);
        chk("R14 low restart latency", n, DEAD + 1);

        // R13: permit drop during hold-off then R14 middle restart
        pwm_code = 2'b01;
        cyc(2);
        run_ok = 0;
        cyc(1);
        chk("R13 gl off mid hold-off", gl_en, 0);
        run_ok = 1;
        stay("R14 middle restart stays off", 15, 0, 0);

        // R14: low in zero-current mode stays off
        zcd_mode = 1;
        pwm_code = 2'b00;
        run_ok = 0;
        cyc(2);
        run_ok = 1;
        stay("R14 zcd low restart stays off", 15, 0, 0);
        pwm_code = 2'b10;
        edges_until(1, 1, n);
        chk("R14 code change after restart", n, DEAD + 1);

        cyc(2);
        chk("R12 no overlap seen", overlap, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule